// File: doc/BRIEF.md
# Secure Hash Message Padder

This block produces the tail that closes a secure-hash message. It is given the message length in bytes and the hash operation code. From these it streams the padding bytes, one per accepted handshake: a single 0x80 marker byte, then enough zero bytes to reach the length-field slot of the final block, then the message length in bits as a big-endian value. The block does not hash and does not count message bytes. It sits beside the engine that already holds the message and needs its final block completed.

Two block geometries exist, and the operation code selects one of them. Codes 6 to 9 (SHA-1, SHA-256 and their keyed-MAC variants) select a 64-byte block with an 8-byte length field. Every other code selects a 128-byte block with a 16-byte length field, and the upper eight bytes of that field are zero. When a request is accepted, the total number of padding bytes appears on a side port, so a consumer can reserve space before the first byte arrives. The output is a byte stream with valid, ready and last.

Top module: `hash_pad_gen`

## Requirements
- R1: While rst_ni is low, and afterwards until a request is accepted, busy_o, out_valid_o and out_last_o are low.
- R2: A request on start_i is taken only in a cycle where busy_o is low. In the following cycle busy_o and out_valid_o are high and out_data_o is 0x80.
- R3: For operation codes 6, 7, 8 and 9, let r be the length modulo 64. After the 0x80 byte come 55-r zero bytes when r is 55 or less, and 119-r zero bytes otherwise.
- R4: For every other operation code, let r be the length modulo 128. After the 0x80 byte come 111-r zero bytes when r is 111 or less, and 239-r otherwise. These are followed by 8 further zero bytes.
- R5: The final 8 bytes carry (length times 8) modulo 2^64, most significant byte first.
- R6: While busy_o is high, pad_len_o equals 1 plus the zero-run length plus the field size (8 or 16). Exactly that many bytes are handed over, and the length plus pad_len_o is a whole number of blocks.
- R7: out_last_o is high only together with the final padding byte. Once that byte is taken, busy_o and out_valid_o are low in the next cycle.
- R8: start_i is ignored while busy_o is high, including the cycle in which the final byte is taken. The running stream and pad_len_o are not altered.
- R9: While out_valid_o is high and out_ready_i is low, out_data_o and out_last_o are held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken when busy_o is low |
| op_i | input | OP_W (4) | Hash operation code |
| len_i | input | LEN_W (64) | Message length in bytes |
| busy_o | output | 1 | A padding stream is in progress |
| pad_len_o | output | CNT_W (8) | Total padding bytes, valid while busy_o |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of the padding |
| out_ready_i | input | 1 | Consumer accepts the byte |

## Verification
The bench pushes lengths that sit on both sides of the length-field boundary: a remainder of exactly 55 or 111 gives the shortest run, and 56 or 112 wraps into an extra block. An off-by-one in the comparison therefore shows up as a stream that is a whole block short or long. Lengths whose bit count overflows 64 bits, and non-zero upper bytes, expose a wrong shift or a reversed byte order in the length field. Wide-mode codes expose a missing run of eight zero bytes. Random back-pressure, together with stray start pulses during a stream, shows whether a design drops or repeats a byte when ready is low. It also shows whether a late request corrupts the stream or restarts it on its final cycle.

// File: rtl/hpad_pkg.sv
package hpad_pkg;
    // Operation codes that select the short (64-byte) block geometry
    localparam int OP_SHA1      = 6;
    localparam int OP_HMAC_SHA1 = 7;
    localparam int OP_SHA256    = 8;
    localparam int OP_HMAC_S256 = 9;

    localparam int NARROW_BLK = 64;
    localparam int NARROW_OFF = 56;
    localparam int NARROW_FLD = 8;
    localparam int WIDE_BLK   = 128;
    localparam int WIDE_OFF   = 112;
    localparam int WIDE_FLD   = 16;

    typedef enum logic [1:0] {
        RGN_MARK,
        RGN_ZERO,
        RGN_LEN
    } rgn_e;
endpackage

// File: rtl/hpad_geom.sv
module hpad_geom
    import hpad_pkg::*;
#(
    parameter int OP_W  = 4,
    parameter int LEN_W = 64,
    parameter int CNT_W = 8
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             wide_o,
    output logic [CNT_W-1:0] zeros_o,
    output logic [CNT_W-1:0] total_o
);
    localparam int RW  = $clog2(WIDE_BLK);
    localparam int NRW = $clog2(NARROW_BLK);

    logic [RW-1:0]    rem;
    logic [CNT_W-1:0] blk;
    logic [CNT_W-1:0] tgt;
    logic [CNT_W-1:0] fld;

    always_comb begin
        wide_o = !((op_i == OP_W'(OP_SHA1))   || (op_i == OP_W'(OP_HMAC_SHA1)) ||
                   (op_i == OP_W'(OP_SHA256)) || (op_i == OP_W'(OP_HMAC_S256)));
        if (wide_o) begin
            blk = CNT_W'(WIDE_BLK);
            tgt = CNT_W'(WIDE_OFF - 1);
            fld = CNT_W'(WIDE_FLD);
            rem = len_i[RW-1:0];
        end else begin
            blk = CNT_W'(NARROW_BLK);
            tgt = CNT_W'(NARROW_OFF - 1);
            fld = CNT_W'(NARROW_FLD);
            rem = RW'(len_i[NRW-1:0]);
        end
        // Zero run: reach the length slot, wrapping into one more block if past it
        if (CNT_W'(rem) <= tgt) begin
            zeros_o = tgt - CNT_W'(rem);
        end else begin
            zeros_o = tgt + blk - CNT_W'(rem);
        end
        total_o = zeros_o + fld + CNT_W'(1);
    end
endmodule

// File: rtl/hpad_seq.sv
module hpad_seq
    import hpad_pkg::*;
#(
    parameter int LEN_W = 64,
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             wide_i,
    input  logic [CNT_W-1:0] zeros_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             ready_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [7:0]       data_o,
    output logic             last_o,
    output logic [CNT_W-1:0] pad_len_o
);
    localparam int LANES  = LEN_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef struct packed {
        logic             busy;
        logic             wide;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] zeros;
        logic [CNT_W-1:0] total;
        logic [LEN_W-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    // Byte lanes of the bit count, lane 0 is the most significant byte
    logic [7:0] lane [LANES];
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = st_q.bits[LEN_W-1-8*g -: 8];
    end

    rgn_e             rgn;
    logic [CNT_W-1:0] pos;
    logic             at_end;
    logic             fire;

    always_comb begin
        pos = st_q.idx - st_q.zeros - CNT_W'(1);
        if (st_q.idx == '0) begin
            rgn = RGN_MARK;
        end else if (st_q.idx <= st_q.zeros) begin
            rgn = RGN_ZERO;
        end else begin
            rgn = RGN_LEN;
        end
        case (rgn)
            RGN_MARK: data_o = 8'h80;
            RGN_ZERO: data_o = 8'h00;
            default: begin
                if (st_q.wide && (pos < CNT_W'(LANES))) begin
                    data_o = 8'h00;
                end else begin
                    data_o = lane[pos[LANE_W-1:0]];
                end
            end
        endcase
    end

    assign at_end    = (st_q.idx == st_q.total - CNT_W'(1));
    assign fire      = st_q.busy && ready_i;
    assign busy_o    = st_q.busy;
    assign valid_o   = st_q.busy;
    assign last_o    = st_q.busy && at_end;
    assign pad_len_o = st_q.total;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load_i) begin
                st_d.busy  = 1'b1;
                st_d.wide  = wide_i;
                st_d.idx   = '0;
                st_d.zeros = zeros_i;
                st_d.total = total_i;
                st_d.bits  = len_i << 3;
            end
        end else if (fire) begin
            if (at_end) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.idx = st_q.idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hash_pad_gen.sv
module hash_pad_gen #(
    parameter int OP_W  = 4,
    parameter int LEN_W = 64,
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] pad_len_o,
    output logic             out_valid_o,
    output logic [7:0]       out_data_o,
    output logic             out_last_o,
    input  logic             out_ready_i
);
    logic             wide;
    logic [CNT_W-1:0] zeros;
    logic [CNT_W-1:0] total;
    logic             load;

    assign load = start_i && !busy_o;

    hpad_geom #(
        .OP_W (OP_W),
        .LEN_W(LEN_W),
        .CNT_W(CNT_W)
    ) u_geom (
        .op_i   (op_i),
        .len_i  (len_i),
        .wide_o (wide),
        .zeros_o(zeros),
        .total_o(total)
    );

    hpad_seq #(
        .LEN_W(LEN_W),
        .CNT_W(CNT_W)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load),
        .wide_i   (wide),
        .zeros_i  (zeros),
        .total_i  (total),
        .len_i    (len_i),
        .ready_i  (out_ready_i),
        .busy_o   (busy_o),
        .valid_o  (out_valid_o),
        .data_o   (out_data_o),
        .last_o   (out_last_o),
        .pad_len_o(pad_len_o)
    );
endmodule

// File: rtl/hpad_chk.sv
module hpad_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             busy_i,
    input logic [CNT_W-1:0] pad_len_i,
    input logic             valid_i,
    input logic [7:0]       data_i,
    input logic             last_i,
    input logic             ready_i
);
    logic [CNT_W:0] sent_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni || !busy_i) begin
            sent_q <= '0;
        end else if (valid_i && ready_i) begin
            sent_q <= sent_q + (CNT_W+1)'(1);
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i |-> (!valid_i && !last_i));

    assert_first_marker_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_i) |-> (valid_i && data_i == 8'h80));

    assert_count_matches_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ready_i && last_i) |-> ((sent_q + (CNT_W+1)'(1)) == (CNT_W+1)'(pad_len_i)));

    assert_last_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ready_i && last_i) |=> !busy_i);

    assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && !(valid_i && ready_i && last_i)) |=> (busy_i && $stable(pad_len_i)));

    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !ready_i) |=> (valid_i && $stable(data_i) && $stable(last_i)));
endmodule

bind hash_pad_gen hpad_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy_o),
    .pad_len_i(pad_len_o),
    .valid_i  (out_valid_o),
    .data_i   (out_data_o),
    .last_i   (out_last_o),
    .ready_i  (out_ready_i)
);

// File: tb/tb_hash_pad_gen.sv
module tb_hash_pad_gen;
    localparam int OP_W  = 4;
    localparam int LEN_W = 64;
    localparam int CNT_W = 8;

    logic             clk_i = 1'b0;
    logic             rst_ni;
    logic             start_i;
    logic [OP_W-1:0]  op_i;
    logic [LEN_W-1:0] len_i;
    logic             busy_o;
    logic [CNT_W-1:0] pad_len_o;
    logic             out_valid_o;
    logic [7:0]       out_data_o;
    logic             out_last_o;
    logic             out_ready_i;

    always #10 clk_i = ~clk_i;

    hash_pad_gen #(.OP_W(OP_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .len_i(len_i),
        .busy_o(busy_o), .pad_len_o(pad_len_o), .out_valid_o(out_valid_o),
        .out_data_o(out_data_o), .out_last_o(out_last_o), .out_ready_i(out_ready_i)
    );

    int          checks = 0;
    int          bad    = 0;
    int          cyc    = 0;
    logic [7:0]  exp_q[$];
    int          tag_q[$];
    int          exp_total;
    longint unsigned cur_len;
    int          cur_blk;
    int          emitted;
    logic        prev_hold = 1'b0;
    logic [7:0]  prev_data = 8'h00;
    logic        prev_last = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    function automatic string tagname(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural model: find the smallest tail length that closes a block
    task automatic load_model(int op, longint unsigned len);
        bit              narrow = (op >= 6 && op <= 9);
        int              blk    = narrow ? 64 : 128;
        int              fld    = narrow ? 8 : 16;
        int              n      = fld + 1;
        longint unsigned bits   = len * 64'd8;
        while (((len % longint'(blk)) + longint'(n)) % longint'(blk) != 0) n++;
        exp_q.delete();
        tag_q.delete();
        exp_q.push_back(8'h80); tag_q.push_back(2);
        for (int i = 0; i < n - 1 - fld; i++) begin
            exp_q.push_back(8'h00); tag_q.push_back(narrow ? 3 : 4);
        end
        if (!narrow) begin
            for (int i = 0; i < 8; i++) begin
                exp_q.push_back(8'h00); tag_q.push_back(4);
            end
        end
        for (int k = 7; k >= 0; k--) begin
            exp_q.push_back(bits[8*k +: 8]); tag_q.push_back(5);
        end
        exp_total = n;
        cur_len   = len;
        cur_blk   = blk;
        emitted   = 0;
    endtask

    // One cycle: check outputs, drive inputs, predict the coming edge
    task automatic tick(bit do_start, int op, longint unsigned len, int rmode, bit stray);
        bit exp_valid = (exp_q.size() > 0);
        bit fire;
        check(out_valid_o == exp_valid, "R6", "valid", longint'(out_valid_o), longint'(exp_valid));
        check(busy_o == exp_valid, "R7", "busy", longint'(busy_o), longint'(exp_valid));
        if (exp_valid) begin
            check(out_data_o == exp_q[0], tagname(tag_q[0]), "data", longint'(out_data_o), longint'(exp_q[0]));
            check(out_last_o == (exp_q.size() == 1), "R7", "last", longint'(out_last_o), longint'(exp_q.size() == 1));
            check(int'(pad_len_o) == exp_total, "R6", "pad_len", longint'(pad_len_o), longint'(exp_total));
            if (prev_hold) begin
                check(out_data_o == prev_data && out_last_o == prev_last, "R9", "held byte",
                      longint'(out_data_o), longint'(prev_data));
            end
        end else begin
            check(out_last_o == 1'b0, "R7", "last idle", longint'(out_last_o), 0);
        end

        case (rmode)
            0: out_ready_i = 1'b1;
            1: out_ready_i = lfsr[3];
            default: out_ready_i = (lfsr[2:0] == 3'b000);
        endcase
        if (do_start) begin
            start_i = 1'b1; op_i = OP_W'(op); len_i = len;
        end else if (stray && exp_valid && lfsr[7]) begin
            // R8: request during a running stream must be ignored
            start_i = 1'b1; op_i = lfsr[11:8]; len_i = {lfsr, lfsr};
        end else begin
            start_i = 1'b0;
        end

        fire      = exp_valid && out_ready_i;
        prev_hold = exp_valid && !out_ready_i;
        prev_data = exp_valid ? exp_q[0] : 8'h00;
        prev_last = exp_valid && (exp_q.size() == 1);
        if (fire) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
            emitted++;
            if (exp_q.size() == 0) begin
                check(((cur_len % longint'(cur_blk)) + longint'(emitted)) % longint'(cur_blk) == 0,
                      "R6", "block closure", longint'(emitted), longint'(exp_total));
            end
        end
        if (start_i && !exp_valid) load_model(int'(op_i), len_i);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        @(negedge clk_i);
    endtask

    task automatic run_stream(int op, longint unsigned len, int rmode, bit stray);
        tick(1'b1, op, len, rmode, stray);
        while (exp_q.size() > 0) tick(1'b0, 0, 0, rmode, stray);
        tick(1'b0, 0, 0, rmode, 1'b0);
    endtask

    always @(posedge clk_i) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", checks + 1, bad);
            $finish;
        end
    end

    initial begin
        rst_ni = 1'b0; start_i = 1'b0; op_i = '0; len_i = '0; out_ready_i = 1'b1;
        repeat (3) @(negedge clk_i);
        check(!busy_o && !out_valid_o && !out_last_o, "R1", "in reset", longint'(out_valid_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check(!busy_o && !out_valid_o && !out_last_o, "R1", "after reset", longint'(busy_o), 0);

        // R3 boundaries, 64-byte geometry
        run_stream(6, 64'd0, 0, 1'b0);
        run_stream(7, 64'd55, 0, 1'b0);
        run_stream(8, 64'd56, 1, 1'b1);
        run_stream(9, 64'd64, 2, 1'b1);
        run_stream(6, 64'd119, 1, 1'b0);
        // R4 boundaries, 128-byte geometry
        run_stream(12, 64'd0, 0, 1'b0);
        run_stream(3, 64'd111, 1, 1'b1);
        run_stream(4, 64'd112, 0, 1'b1);
        run_stream(0, 64'd127, 2, 1'b0);
        run_stream(15, 64'd200, 1, 1'b1);
        // R5 byte order and bit-count wrap
        run_stream(13, 64'hFFFF_FFFF_FFFF_FFF0, 1, 1'b1);
        run_stream(8, 64'h0123_4567_89AB_CDEF, 0, 1'b1);
        run_stream(10, 64'd1000003, 2, 1'b1);
        for (int i = 0; i < 20; i++) begin
            run_stream(int'(lfsr[3:0]), {32'd0, lfsr}, i % 3, 1'b1);
        end

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule